// File: doc/BRIEF.md
# Clarke and Park Coordinate Transform Engine

This block converts motor-control quantities between three coordinate frames: the three-phase frame, the stationary two-axis (alpha/beta) frame and the rotating two-axis (d/q) frame. It offers four operations: forward and reverse Clarke, and forward and reverse Park. All operands and results are 12-bit two's-complement values. A command is accepted on a valid/ready input channel and carries the operation code, two operands and a 12-bit electrical angle. The three results come back on a valid/ready output channel.

The angle's sine and cosine are produced inside the block by an iterative CORDIC rotation. A single multiply-accumulate unit then computes each result in turn, using a weighted sum of the two operands. Every operation takes the same fixed number of cycles, whether or not it uses the angle. Each result is rounded and then clamped to the 12-bit range.

Back-pressure rules: a command transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from acceptance until the results are handed off, so a command presented in that window is not taken and has no effect. Once `out_valid` rises, it and the three results hold steady until a clock edge with `out_ready` high. On the following cycle the engine is ready for a new command.

Top module: `xform_engine`

## Requirements
- R1: After reset, with no command pending, `in_ready` is 1, `busy` is 0 and `out_valid` is 0. A command is accepted on an edge where `in_valid` and `in_ready` are both 1, and `busy` is 1 from the next cycle.
- R2: Op code 2'b00 (forward Clarke) takes x=a and y=b and returns r0=a, r1=(a+2b)/sqrt(3) and r2=0, each within 1 LSB before clamping.
- R3: Op code 2'b01 (reverse Clarke) takes x=alpha and y=beta and returns r0=alpha, r1=-alpha/2+beta*sqrt(3)/2 and r2=-(r0+r1)=-alpha/2-beta*sqrt(3)/2, each within 1 LSB.
- R4: Op code 2'b10 (forward Park) takes x=alpha, y=beta and angle theta, where 4096 angle codes make one electrical revolution. It returns r0=alpha*cos+beta*sin, r1=-alpha*sin+beta*cos and r2=0, the first two within 3 LSB.
- R5: Op code 2'b11 (reverse Park) takes x=d, y=q and angle theta. It returns r0=d*cos-q*sin, r1=d*sin+q*cos and r2=0, the first two within 3 LSB.
- R6: A result whose exact value lies outside -2048..2047 is returned as exactly 2047 or -2048, and is never wrapped.
- R7: `out_valid` rises exactly 17 clock edges (ITERS+3) after the accepting edge, for every op code.
- R8: While `busy` is 1, `in_ready` is 0. Commands presented then are not accepted and do not change the pending results.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_r0`..`out_r2` hold. After the edge where `out_ready` is 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Engine can take a command |
| in_op | input | 2 | Operation: 00 fwd Clarke, 01 rev Clarke, 10 fwd Park, 11 rev Park |
| in_x | input | 12 | First operand, two's complement |
| in_y | input | 12 | Second operand, two's complement |
| in_ang | input | 12 | Electrical angle, full scale is one revolution |
| out_valid | output | 1 | Results present |
| out_ready | input | 1 | Consumer takes results |
| out_r0 | output | 12 | First result |
| out_r1 | output | 12 | Second result |
| out_r2 | output | 12 | Third result (zero unless reverse Clarke) |
| busy | output | 1 | Command in progress or results unconsumed |

## Verification
The bench checks each quadrant of the angle, including codes 0, 1024, 2048 and 4095. A wrong quadrant fold in the sine/cosine stage would flip the sign of the d or q result, or swap the two. Inputs near full scale test clamping: a design that wraps instead of saturating would return a large value of the opposite sign where 2047 or -2048 is expected. Commands are also presented while a transform is in flight. A design that accepted them would corrupt the pending results or show a shortened latency. Finally, the output is stalled for several cycles. A design that dropped or changed results under back-pressure, or re-armed `in_ready` early, is caught there.

// File: rtl/xform_pkg.sv
package xform_pkg;

  // coefficient word width and fraction bits (1.0 == 2**QFRAC)
  localparam int CW    = 18;
  localparam int QFRAC = 15;
  // CORDIC angle word: 2**ZREV codes per revolution
  localparam int ZREV  = 16;
  localparam int ZW    = 18;

  typedef enum logic [1:0] {
    OP_CLARKE_FWD = 2'b00,
    OP_CLARKE_REV = 2'b01,
    OP_PARK_FWD   = 2'b10,
    OP_PARK_REV   = 2'b11
  } xop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROT  = 2'd1,
    ST_MAC  = 2'd2,
    ST_HOLD = 2'd3
  } eng_st_e;

  localparam logic signed [CW-1:0] Q_ONE       = 18'sd32768;
  localparam logic signed [CW-1:0] Q_HALF      = 18'sd16384;
  localparam logic signed [CW-1:0] Q_INV_RT3   = 18'sd18919;
  localparam logic signed [CW-1:0] Q_2INV_RT3  = 18'sd37837;
  localparam logic signed [CW-1:0] Q_RT3_HALF  = 18'sd28378;
  localparam logic signed [CW-1:0] Q_ZERO      = 18'sd0;
  // start length of the CORDIC vector: product of cos(atan(2**-i))
  localparam logic signed [CW-1:0] Q_CORDIC_K  = 18'sd19898;

  // elementary rotation angle atan(2**-i) in units of 2**-ZREV revolution
  function automatic logic signed [ZW-1:0] rot_step_angle(input int i);
    case (i)
      0:  rot_step_angle = 18'sd8192;
      1:  rot_step_angle = 18'sd4836;
      2:  rot_step_angle = 18'sd2555;
      3:  rot_step_angle = 18'sd1297;
      4:  rot_step_angle = 18'sd651;
      5:  rot_step_angle = 18'sd326;
      6:  rot_step_angle = 18'sd163;
      7:  rot_step_angle = 18'sd81;
      8:  rot_step_angle = 18'sd41;
      9:  rot_step_angle = 18'sd20;
      10: rot_step_angle = 18'sd10;
      11: rot_step_angle = 18'sd5;
      12: rot_step_angle = 18'sd3;
      13: rot_step_angle = 18'sd1;
      14: rot_step_angle = 18'sd1;
      default: rot_step_angle = 18'sd0;
    endcase
  endfunction

endpackage

// File: rtl/xform_sincos.sv
module xform_sincos
  import xform_pkg::*;
#(
  parameter int ANG_W = 12,
  parameter int ITERS = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic [ANG_W-1:0]     ang,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o,
  output logic                 last_o
);

  localparam int IW  = $clog2(ITERS + 1);
  localparam int ZSH = ZREV - ANG_W;
  localparam logic signed [CW-1:0] MAG_BOUND = Q_ONE + 18'sd512;

  logic signed [CW-1:0] vx_q, vy_q;
  logic signed [ZW-1:0] z_q;
  logic [1:0]           quad_q;
  logic [IW-1:0]        itr_q;

  logic signed [CW-1:0] vx_sh, vy_sh;
  logic signed [ZW-1:0] z_init, step_ang;

  always_comb begin
    z_init   = ZW'(ang[ANG_W-3:0]) <<< ZSH;
    vx_sh    = vx_q >>> itr_q;
    vy_sh    = vy_q >>> itr_q;
    step_ang = rot_step_angle(int'(itr_q));
  end

  // residual angle lies in [0, quarter turn); rotate toward it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vx_q   <= Q_CORDIC_K;
      vy_q   <= '0;
      z_q    <= '0;
      quad_q <= '0;
      itr_q  <= '0;
    end else if (load) begin
      vx_q   <= Q_CORDIC_K;
      vy_q   <= '0;
      z_q    <= z_init;
      quad_q <= ang[ANG_W-1:ANG_W-2];
      itr_q  <= '0;
    end else if (step) begin
      if (!z_q[ZW-1]) begin
        vx_q <= vx_q - vy_sh;
        vy_q <= vy_q + vx_sh;
        z_q  <= z_q - step_ang;
      end else begin
        vx_q <= vx_q + vy_sh;
        vy_q <= vy_q - vx_sh;
        z_q  <= z_q + step_ang;
      end
      itr_q <= itr_q + IW'(1);
    end
  end

  assign last_o = (itr_q == IW'(ITERS - 1));

  // unfold the quadrant taken from the two top angle bits
  always_comb begin
    unique case (quad_q)
      2'd0: begin cos_o = vx_q;  sin_o = vy_q;  end
      2'd1: begin cos_o = -vy_q; sin_o = vx_q;  end
      2'd2: begin cos_o = -vx_q; sin_o = -vy_q; end
      default: begin cos_o = vy_q; sin_o = -vx_q; end
    endcase
  end

  // R4: the rotating vector never grows past unit length plus margin
  a_r4_sincos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_o <= MAG_BOUND) && (cos_o >= -MAG_BOUND) &&
    (sin_o <= MAG_BOUND) && (sin_o >= -MAG_BOUND));

endmodule

// File: rtl/xform_coef_sel.sv
module xform_coef_sel
  import xform_pkg::*;
(
  input  xop_e                 op,
  input  logic [1:0]           slot,
  input  logic signed [CW-1:0] cos_i,
  input  logic signed [CW-1:0] sin_i,
  output logic signed [CW-1:0] kx,
  output logic signed [CW-1:0] ky
);

  // result[slot] = x*kx + y*ky
  always_comb begin
    kx = Q_ZERO;
    ky = Q_ZERO;
    unique case (op)
      OP_CLARKE_FWD: begin
        if (slot == 2'd0) begin kx = Q_ONE; end
        else if (slot == 2'd1) begin kx = Q_INV_RT3; ky = Q_2INV_RT3; end
      end
      OP_CLARKE_REV: begin
        if (slot == 2'd0) begin kx = Q_ONE; end
        else if (slot == 2'd1) begin kx = -Q_HALF; ky = Q_RT3_HALF; end
        else if (slot == 2'd2) begin kx = -Q_HALF; ky = -Q_RT3_HALF; end
      end
      OP_PARK_FWD: begin
        if (slot == 2'd0) begin kx = cos_i; ky = sin_i; end
        else if (slot == 2'd1) begin kx = -sin_i; ky = cos_i; end
      end
      default: begin
        if (slot == 2'd0) begin kx = cos_i; ky = -sin_i; end
        else if (slot == 2'd1) begin kx = sin_i; ky = cos_i; end
      end
    endcase
  end

endmodule

// File: rtl/xform_mac.sv
module xform_mac
  import xform_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] opx,
  input  logic signed [DATA_W-1:0] opy,
  input  logic signed [CW-1:0]     kx,
  input  logic signed [CW-1:0]     ky,
  output logic signed [DATA_W-1:0] res
);

  localparam int PW = DATA_W + CW + 2;
  localparam logic signed [PW-1:0] SAT_HI   = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] SAT_LO   = -SAT_HI - PW'(1);
  localparam logic signed [PW-1:0] HALF_LSB = PW'(64'sd1 <<< (QFRAC - 1));

  logic signed [PW-1:0] px, py, acc, scaled;

  always_comb begin
    px     = PW'(opx) * PW'(kx);
    py     = PW'(opy) * PW'(ky);
    acc    = px + py;
    scaled = (acc + HALF_LSB) >>> QFRAC;
    if (scaled > SAT_HI)      res = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) res = SAT_LO[DATA_W-1:0];
    else                      res = scaled[DATA_W-1:0];
  end

endmodule

// File: rtl/xform_engine.sv
module xform_engine
  import xform_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ANG_W  = 12,
  parameter int ITERS  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  input  logic [ANG_W-1:0]  in_ang,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_r0,
  output logic [DATA_W-1:0] out_r1,
  output logic [DATA_W-1:0] out_r2,
  output logic              busy
);

  localparam int NRES = 3;
  localparam int LAT  = ITERS + NRES;
  localparam int LCW  = $clog2(LAT + 2);

  eng_st_e                   st_q;
  xop_e                      op_q;
  logic signed [DATA_W-1:0]  x_q, y_q;
  logic [1:0]                slot_q;
  logic signed [DATA_W-1:0]  res_q [NRES];

  logic                      accept, rot_step, rot_last;
  logic signed [CW-1:0]      cos_w, sin_w, kx_w, ky_w;
  logic signed [DATA_W-1:0]  mac_res;

  assign accept   = (st_q == ST_IDLE) && in_valid;
  assign rot_step = (st_q == ST_ROT);

  xform_sincos #(.ANG_W(ANG_W), .ITERS(ITERS)) u_sincos (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (rot_step),
    .ang    (in_ang),
    .cos_o  (cos_w),
    .sin_o  (sin_w),
    .last_o (rot_last)
  );

  xform_coef_sel u_coef (
    .op    (op_q),
    .slot  (slot_q),
    .cos_i (cos_w),
    .sin_i (sin_w),
    .kx    (kx_w),
    .ky    (ky_w)
  );

  xform_mac #(.DATA_W(DATA_W)) u_mac (
    .opx (x_q),
    .opy (y_q),
    .kx  (kx_w),
    .ky  (ky_w),
    .res (mac_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CLARKE_FWD;
      x_q    <= '0;
      y_q    <= '0;
      slot_q <= '0;
      for (int i = 0; i < NRES; i++) res_q[i] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            st_q   <= ST_ROT;
            op_q   <= xop_e'(in_op);
            x_q    <= in_x;
            y_q    <= in_y;
            slot_q <= '0;
          end
        end
        ST_ROT: begin
          if (rot_last) st_q <= ST_MAC;
        end
        ST_MAC: begin
          res_q[slot_q] <= mac_res;
          slot_q        <= slot_q + 2'd1;
          if (slot_q == 2'(NRES - 1)) st_q <= ST_HOLD;
        end
        default: begin
          if (out_ready) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign out_r0    = res_q[0];
  assign out_r1    = res_q[1];
  assign out_r2    = res_q[2];

  // checker-side latency counter (R7)
  logic [LCW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_cnt <= '0;
    else if (in_valid && in_ready) lat_cnt <= '0;
    else if (busy && !out_valid)   lat_cnt <= lat_cnt + LCW'(1);
  end

  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !out_valid));

  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == LCW'(LAT)));

  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(x_q) && $stable(y_q) && $stable(op_q)));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r0) && $stable(out_r1) && $stable(out_r2)));

endmodule

// File: tb/xform_engine_tb_top.sv
module xform_engine_tb_top;

  localparam int LAT = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [11:0] in_x = '0;
  logic [11:0] in_y = '0;
  logic [11:0] in_ang = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_r0, out_r1, out_r2;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xform_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_x(in_x), .in_y(in_y), .in_ang(in_ang),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r0(out_r0), .out_r1(out_r1), .out_r2(out_r2), .busy(busy)
  );

  task automatic check(input string req, input int got, input int exp, input int tol);
    int d = got - exp;
    n_chk++;
    if (d > tol || d < -tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d tol=%0d", req, got, exp, tol);
    end
  endtask

  function automatic int rnd_sat(input real v);
    int t = $rtoi($floor(v + 0.5));
    if (t > 2047) t = 2047;
    if (t < -2048) t = -2048;
    return t;
  endfunction

  function automatic int sx(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic model(input logic [1:0] op, input int x, input int y, input int ang,
                       output int e0, output int e1, output int e2);
    real th = real'(ang) * 2.0 * 3.14159265358979 / 4096.0;
    real c = $cos(th);
    real s = $sin(th);
    real r3 = $sqrt(3.0);
    case (op)
      2'b00: begin e0 = rnd_sat(x); e1 = rnd_sat((x + 2.0 * y) / r3); e2 = 0; end
      2'b01: begin e0 = rnd_sat(x); e1 = rnd_sat(-0.5 * x + r3 / 2.0 * y);
                   e2 = rnd_sat(-0.5 * x - r3 / 2.0 * y); end
      2'b10: begin e0 = rnd_sat(x * c + y * s); e1 = rnd_sat(-x * s + y * c); e2 = 0; end
      default: begin e0 = rnd_sat(x * c - y * s); e1 = rnd_sat(x * s + y * c); e2 = 0; end
    endcase
  endtask

  // present one command; returns at the falling edge after acceptance
  task automatic send(input logic [1:0] op, input int x, input int y, input int ang);
    @(negedge clk);
    check("R1 in_ready before accept", int'(in_ready), 1, 0);
    in_valid = 1'b1; in_op = op; in_x = 12'(x); in_y = 12'(y); in_ang = 12'(ang);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 busy after accept", int'(busy), 1, 0);
  endtask

  task automatic wait_result(input int n0);
    int n = n0;
    while (!out_valid && n < 100) begin
      @(posedge clk); n++; @(negedge clk);
    end
    check("R7 latency", n, LAT, 0);
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input int x, input int y,
                        input int ang, input int tol, output int g0, output int g1, output int g2);
    int e0, e1, e2;
    model(op, x, y, ang, e0, e1, e2);
    send(op, x, y, ang);
    wait_result(0);
    g0 = sx(out_r0); g1 = sx(out_r1); g2 = sx(out_r2);
    check({req, " r0"}, g0, e0, tol);
    check({req, " r1"}, g1, e1, tol);
    check({req, " r2"}, g2, e2, (op == 2'b01) ? tol : 0);
    take();
  endtask

  task automatic t_reset();
    check("R1 reset in_ready", int'(in_ready), 1, 0);
    check("R1 reset busy", int'(busy), 0, 0);
    check("R1 reset out_valid", int'(out_valid), 0, 0);
  endtask

  task automatic t_clarke_fwd();
    int g0, g1, g2;
    run_op("R2 fwd clarke", 2'b00, 1000, 1000, 0, 1, g0, g1, g2);
    run_op("R2 fwd clarke", 2'b00, 300, -700, 77, 1, g0, g1, g2);
    run_op("R2 fwd clarke", 2'b00, -512, 256, 0, 1, g0, g1, g2);
  endtask

  task automatic t_clarke_rev();
    int g0, g1, g2;
    run_op("R3 rev clarke", 2'b01, 1000, 0, 0, 1, g0, g1, g2);
    run_op("R3 rev clarke", 2'b01, 0, 1500, 0, 1, g0, g1, g2);
    run_op("R3 rev clarke", 2'b01, -800, 400, 3000, 1, g0, g1, g2);
  endtask

  task automatic t_park_fwd();
    int g0, g1, g2;
    int angs[6] = '{0, 512, 1024, 2048, 3000, 4095};
    foreach (angs[i]) run_op("R4 fwd park", 2'b10, 1000, 500, angs[i], 3, g0, g1, g2);
    run_op("R4 fwd park", 2'b10, -700, 1200, 1700, 3, g0, g1, g2);
  endtask

  task automatic t_park_rev();
    int g0, g1, g2, h0, h1, h2;
    run_op("R5 rev park", 2'b11, 900, -300, 700, 3, g0, g1, g2);
    run_op("R5 rev park", 2'b11, -1200, 800, 3500, 3, g0, g1, g2);
    // round trip: forward then reverse at the same angle
    run_op("R4 fwd park", 2'b10, 600, -900, 2600, 3, g0, g1, g2);
    run_op("R5 rev park", 2'b11, g0, g1, 2600, 3, h0, h1, h2);
    check("R5 round trip alpha", h0, 600, 4);
    check("R5 round trip beta", h1, -900, 4);
  endtask

  task automatic t_saturation();
    int g0, g1, g2;
    run_op("R6 fwd clarke hi", 2'b00, 2047, 2047, 0, 1, g0, g1, g2);
    check("R6 clamp high exact", g1, 2047, 0);
    run_op("R6 fwd clarke lo", 2'b00, -2048, -2048, 0, 1, g0, g1, g2);
    check("R6 clamp low exact", g1, -2048, 0);
    run_op("R6 rev clarke", 2'b01, 2047, -2047, 0, 1, g0, g1, g2);
    check("R6 clamp b exact", g1, -2048, 0);
    run_op("R6 fwd park", 2'b10, 2047, 2047, 512, 3, g0, g1, g2);
    check("R6 clamp d exact", g0, 2047, 0);
  endtask

  task automatic t_busy_ignore();
    int e0, e1, e2;
    model(2'b10, 800, -400, 900, e0, e1, e2);
    send(2'b10, 800, -400, 900);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_op = 2'b01; in_x = 12'(-1500); in_y = 12'(1900); in_ang = 12'd100;
      check("R8 in_ready low while busy", int'(in_ready), 0, 0);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_result(5);
    check("R8 first result kept r0", sx(out_r0), e0, 3);
    check("R8 first result kept r1", sx(out_r1), e1, 3);
    check("R8 first result kept r2", sx(out_r2), 0, 0);
    take();
  endtask

  task automatic t_backpressure();
    int h0, h1, h2;
    send(2'b01, -600, 1100, 0);
    wait_result(0);
    h0 = sx(out_r0); h1 = sx(out_r1); h2 = sx(out_r2);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9 out_valid held", int'(out_valid), 1, 0);
      check("R9 in_ready low in stall", int'(in_ready), 0, 0);
      check("R9 r0 stable", sx(out_r0), h0, 0);
      check("R9 r1 stable", sx(out_r1), h1, 0);
      check("R9 r2 stable", sx(out_r2), h2, 0);
    end
    take();
    check("R9 out_valid cleared", int'(out_valid), 0, 0);
    check("R9 ready after handoff", int'(in_ready), 1, 0);
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clarke_fwd();
    t_clarke_rev();
    t_park_fwd();
    t_park_rev();
    t_saturation();
    t_busy_ignore();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule